// File: doc/BRIEF.md
# Strobe-Latched Control Register Bank

This block keeps three 8-bit control registers (system, monitor and clock/routing) that are loaded from one shared 8-bit data bus. A host places a byte on the bus, pulls the shared active-low output enable low, then pulses the active-low select of the target register. The register loads the bus value when its select returns high. The enable and the selects come from another timing domain, so each passes through a two-flop synchroniser, and the rising edge of a select is found in the system clock domain. The register changes on the third rising clock edge after its select rises.

Besides the raw contents, the block decodes the clock register combinationally. It gives the internal sample-rate index, the internal/external sync flag and the external clock type, and it raises a flag for any combination it does not allow. It also flags the reserved input 1/2 mode code in the system register. Other logic that drives relays, phantom power and clock generation reads these outputs directly.

Top module: `strobe_regbank`

## Requirements
- R1: After reset the system register reads 8'h08 (only bit 3, phantom off, set; bit 7 clear, so the codec stays powered down), and the monitor and clock registers read 8'h00.
- R2: A select (system, monitor or clock) that goes low and then high while the enable is held low loads `bus_d` into that register only. The new value appears on the third rising clock edge after the select rises.
- R3: A select edge while the enable is high leaves all three registers unchanged.
- R4: A select that is already low while reset is asserted and rises after reset is released is discarded.
- R5: Selects that rise together in the same cycle load the same bus byte into each selected register.
- R6: With clock register bit 3 = 0 (internal), `rate_idx` equals bits [2:0] (0=44.1k, 1=48k, 2=88.2k, 3=96k, 4=176.4k, 5=192k), and `clk_illegal` is 1 exactly for codes 6 and 7. Bit 4 is ignored.
- R7: With bit 3 = 1 (external), bits {4,2:0} decode as follows: {0,000} gives `ext_type`=0 (S/PDIF), {0,010} gives 1 (word clock 1×fs) and {1,010} gives 2 (word clock 256×fs). Any other value sets `clk_illegal`. `ext_type` reads 3 when the clock is internal or the code is illegal.
- R8: `in12_reserved` is 1 exactly when system register bits [5:4] equal 2'b10. The codes 00 (line), 01 (mic) and 11 (mic with low-cut) are legal.
- R9: `sync_ext` follows clock register bit 3, and `rate_idx` always shows bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Shared write data bus |
| oe_n | input | 1 | Shared active-low output enable |
| sel_sys_n | input | 1 | Active-low select, system register |
| sel_mon_n | input | 1 | Active-low select, monitor register |
| sel_clk_n | input | 1 | Active-low select, clock/routing register |
| sys_reg | output | 8 | System register contents |
| mon_reg | output | 8 | Monitor register contents |
| clk_reg | output | 8 | Clock/routing register contents |
| rate_idx | output | 3 | Internal rate index (clock bits [2:0]) |
| sync_ext | output | 1 | External sync selected |
| ext_type | output | 2 | External source type, 3 when none |
| clk_illegal | output | 1 | Illegal clock register combination |
| in12_reserved | output | 1 | Reserved input 1/2 mode code present |

## Verification
Two select edges can be detected in the same clock cycle, and both registers must then load the same bus byte without the two loads interfering. The bench provokes this with directed and random multi-select writes, where both selects drop and rise at the same instant, and it compares all three registers against a model that loads every selected register. A second collision comes from a select whose low phase overlaps reset: it must be discarded rather than treated as a fresh edge. The bench checks this by holding the clock register select low across reset release and confirming the register keeps its reset value after the select rises.

// File: rtl/strobe_regbank.sv
module strobe_regbank #(
  parameter int          W       = 8,
  parameter logic [W-1:0] SYS_RST = 8'h08
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_d,
  input  logic         oe_n,
  input  logic         sel_sys_n,
  input  logic         sel_mon_n,
  input  logic         sel_clk_n,
  output logic [W-1:0] sys_reg,
  output logic [W-1:0] mon_reg,
  output logic [W-1:0] clk_reg,
  output logic [2:0]   rate_idx,
  output logic         sync_ext,
  output logic [1:0]   ext_type,
  output logic         clk_illegal,
  output logic         in12_reserved
);

  localparam int NSEL = 3;

  logic [NSEL-1:0] s1, s2, s3, armed;
  logic            oe1, oe2;
  logic [NSEL-1:0] wr;

  // selects and enable cross into clk domain; sync flops reset low so a
  // select that never shows high after reset cannot count as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      s3    <= '0;
      armed <= '0;
      oe1   <= 1'b1;
      oe2   <= 1'b1;
    end else begin
      s1    <= {sel_clk_n, sel_mon_n, sel_sys_n};
      s2    <= s1;
      s3    <= s2;
      armed <= armed | s3;
      oe1   <= oe_n;
      oe2   <= oe1;
    end
  end

  assign wr = s2 & ~s3 & armed & {NSEL{~oe2}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_reg <= SYS_RST;
      mon_reg <= '0;
      clk_reg <= '0;
    end else begin
      if (wr[0]) sys_reg <= bus_d;
      if (wr[1]) mon_reg <= bus_d;
      if (wr[2]) clk_reg <= bus_d;
    end
  end

  assign rate_idx      = clk_reg[2:0];
  assign sync_ext      = clk_reg[3];
  assign in12_reserved = (sys_reg[5:4] == 2'b10);

  always_comb begin
    ext_type    = 2'd3;
    clk_illegal = 1'b0;
    if (!clk_reg[3]) begin
      clk_illegal = (clk_reg[2:1] == 2'b11);
    end else begin
      case ({clk_reg[4], clk_reg[2:0]})
        4'b0000: ext_type = 2'd0;
        4'b0010: ext_type = 2'd1;
        4'b1010: ext_type = 2'd2;
        default: clk_illegal = 1'b1;
      endcase
    end
  end

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr[0] |=> sys_reg == $past(bus_d));

  p_hold_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe2 |=> $stable({sys_reg, mon_reg, clk_reg}));

  p_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed[2] |=> $stable(clk_reg));

  p_int_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ext && rate_idx > 3'd5) |-> clk_illegal);

  p_ext_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_type != 2'd3) |-> (sync_ext && !clk_illegal));

endmodule

// File: tb/sim_strobe_regbank.sv
module sim_strobe_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_d = 8'h00;
  logic       oe_n = 1'b1;
  logic       sel_sys_n = 1'b1, sel_mon_n = 1'b1, sel_clk_n = 1'b1;
  logic [7:0] sys_reg, mon_reg, clk_reg;
  logic [2:0] rate_idx;
  logic       sync_ext, clk_illegal, in12_reserved;
  logic [1:0] ext_type;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_sys, m_mon, m_clk;

  always #5 clk = ~clk;

  strobe_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .oe_n(oe_n),
    .sel_sys_n(sel_sys_n), .sel_mon_n(sel_mon_n), .sel_clk_n(sel_clk_n),
    .sys_reg(sys_reg), .mon_reg(mon_reg), .clk_reg(clk_reg),
    .rate_idx(rate_idx), .sync_ext(sync_ext), .ext_type(ext_type),
    .clk_illegal(clk_illegal), .in12_reserved(in12_reserved));

  function automatic logic f_illegal(logic [7:0] c);
    if (!c[3]) return c[2:1] == 2'b11;
    return !(c[2:0] == 3'b000 && !c[4]) && !(c[2:0] == 3'b010);
  endfunction

  function automatic logic [1:0] f_ext(logic [7:0] c);
    if (!c[3] || f_illegal(c)) return 2'd3;
    if (c[2:0] == 3'b000) return 2'd0;
    return c[4] ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "sys_reg", sys_reg, m_sys);
    chk(req, "mon_reg", mon_reg, m_mon);
    chk(req, "clk_reg", clk_reg, m_clk);
    chk("R9", "rate_idx", {5'd0, rate_idx}, {5'd0, m_clk[2:0]});
    chk("R9", "sync_ext", {7'd0, sync_ext}, {7'd0, m_clk[3]});
    chk("R6/R7", "clk_illegal", {7'd0, clk_illegal}, {7'd0, f_illegal(m_clk)});
    chk("R7", "ext_type", {6'd0, ext_type}, {6'd0, f_ext(m_clk)});
    chk("R8", "in12_reserved", {7'd0, in12_reserved}, {7'd0, m_sys[5:4] == 2'b10});
  endtask

  task automatic do_write(logic [2:0] mask, logic [7:0] d, bit en, string req);
    @(negedge clk);
    bus_d = d;
    oe_n  = !en;
    repeat (3) @(negedge clk);
    sel_sys_n = !mask[0];
    sel_mon_n = !mask[1];
    sel_clk_n = !mask[2];
    repeat (4) @(negedge clk);
    sel_sys_n = 1'b1; sel_mon_n = 1'b1; sel_clk_n = 1'b1;
    repeat (5) @(negedge clk);
    oe_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_d = 8'($urandom);
    if (en) begin
      if (mask[0]) m_sys = d;
      if (mask[1]) m_mon = d;
      if (mask[2]) m_clk = d;
    end
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_sys = 8'h08; m_mon = 8'h00; m_clk = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_all("R1");

    do_write(3'b001, 8'hA5, 1, "R2");
    do_write(3'b010, 8'h3C, 1, "R2");
    do_write(3'b100, 8'h03, 1, "R2");
    do_write(3'b100, 8'hFF, 0, "R3");
    do_write(3'b111, 8'h00, 0, "R3");
    do_write(3'b011, 8'h5A, 1, "R5");
    do_write(3'b111, 8'h1A, 1, "R5");
    do_write(3'b100, 8'h06, 1, "R6");
    do_write(3'b100, 8'h17, 1, "R6");
    do_write(3'b100, 8'h15, 1, "R6");
    do_write(3'b100, 8'h08, 1, "R7");
    do_write(3'b100, 8'h0A, 1, "R7");
    do_write(3'b100, 8'h18, 1, "R7");
    do_write(3'b100, 8'h09, 1, "R7");
    do_write(3'b001, 8'h20, 1, "R8");
    do_write(3'b001, 8'h30, 1, "R8");

    // R4: select low across reset release must not produce a write
    @(negedge clk);
    rst_n = 1'b0; oe_n = 1'b0; sel_clk_n = 1'b0; bus_d = 8'hFF;
    m_sys = 8'h08; m_mon = 8'h00; m_clk = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sel_clk_n = 1'b1;
    repeat (6) @(negedge clk);
    oe_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R4");
    do_write(3'b100, 8'h01, 1, "R4");

    for (int i = 0; i < 60; i++) begin
      logic [2:0] mk;
      mk = 3'($urandom_range(1, 7));
      do_write(mk, 8'($urandom), ($urandom % 5) != 0, "R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule